// File: doc/BRIEF.md
# Masked Packed Signed-Integer to Single-Precision Converter

This block turns a vector of signed 64-bit integers into IEEE-754 single-precision values. A vector-length select picks how many lanes are active: 2, 4 or 8. Each 64-bit source element produces a 32-bit result, so the results fill the lower half of the selected width. Every bit of the 512-bit destination above that half is cleared.

A per-lane writemask decides which lanes are converted. When the mask is disabled, every active lane is converted. A lane whose mask bit is clear either keeps its old destination value (merging) or becomes zero (zeroing). In broadcast mode the lowest source element feeds every lane. Rounding is round-to-nearest-even unless a rounding override is given, and the override is legal only for the full 512-bit, non-broadcast form. A 4-bit reserved specifier field must read all ones.

The block also reports an inexact flag for the converted lanes, and an illegal flag for any encoding it does not accept. All outputs are registered, so a result appears one clock after its inputs.

Top module: `i2f_pack`

## Requirements
- R1: `vl_sel_i` encodes the lane count: 0 gives 2 lanes, 1 gives 4 and 2 gives 8. Lane j reads `src_i[64j+63:64j]` and writes `dst_o[32j+31:32j]`. Outputs change one clock edge after the inputs.
- R2: A converted lane holds the single-precision value of its signed element: bit 31 is the sign, bits 30:23 the exponent with bias 127, and bits 22:0 the fraction. Input 0 gives 0x00000000.
- R3: The override bit is `rnd_i[2]`, and when it is set, `rnd_i[1:0]` selects the rounding: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. When `rnd_i[2]` is 0, nearest-even is used.
- R4: When `mask_en_i` is 0, all active lanes are converted. When `mask_en_i` is 1 and `mask_i[j]` is 0, lane j takes `old_dst_i[32j+31:32j]` if `zero_mode_i` is 0, and takes zero if `zero_mode_i` is 1.
- R5: With `bcast_i` set, every converted lane uses `src_i[63:0]`.
- R6: Every `dst_o` bit at or above 32 times the lane count is 0, whatever the old destination holds.
- R7: `illegal_o` is set when any of these holds: `resv_i` is not 4'b1111, `vl_sel_i` is 3, or `rnd_i[2]` is set together with a non-512 length or with broadcast. While `illegal_o` is set, `dst_o` is all zero and `inexact_o` is 0.
- R8: `inexact_o` is the OR, over converted lanes only, of "rounded result differs from the integer". A masked-off lane or a lane beyond the length never sets it.
- R9: While reset is asserted (`rst_ni` low), `dst_o`, `inexact_o` and `illegal_o` are 0.
- R10: When rounding carries out of the significand, the exponent goes up by one. For example, 0x1FFFFFF under nearest-even gives 0x4C000000. The most negative input, -2^63, gives 0xDF000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 512 | Packed signed 64-bit source elements |
| old_dst_i | input | 512 | Previous destination, used for merging |
| mask_i | input | 8 | Per-lane writemask |
| mask_en_i | input | 1 | 1: apply the writemask |
| vl_sel_i | input | 2 | Vector-length select |
| zero_mode_i | input | 1 | 1: zeroing, 0: merging |
| bcast_i | input | 1 | Broadcast the lowest source element |
| rnd_i | input | 3 | Bit 2 is the override bit; bits 1:0 select the rounding mode |
| resv_i | input | 4 | Reserved specifier, must be 4'b1111 |
| dst_o | output | 512 | Result vector |
| inexact_o | output | 1 | Some converted lane was rounded |
| illegal_o | output | 1 | Illegal encoding |

## Verification
Small exact integers such as ±1, ±2 and 100 check the sign, exponent and fraction packing, and placing them in different lanes shows the lane-to-slot mapping for each length. Values one or three past 2^24, together with 0x1FFFFFF and 2^63-1, are run under all four rounding modes. These separate a tie broken to even from a tie rounded up, show the direction each mode takes for negative values, and cover the exponent carry. Alternating mask patterns under merging and under zeroing separate the two masked behaviours. A broadcast case with differing upper elements shows that only element 0 is used, and an inexact value placed in a masked lane or beyond the length shows that those lanes do not feed the flag.

// File: rtl/i2f_pack_pkg.sv
package i2f_pack_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    LEN_2   = 2'b00,
    LEN_4   = 2'b01,
    LEN_8   = 2'b10,
    LEN_BAD = 2'b11
  } vlen_e;

  localparam logic [3:0] RESV_OK = 4'b1111;
endpackage

// File: rtl/i2f_pack_lzc.sv
module i2f_pack_lzc #(
  parameter int W  = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) cnt_o = CW'(W - 1 - i);
    end
    zero_o = (val_i == '0);
  end
endmodule

// File: rtl/i2f_pack_conv.sv
module i2f_pack_conv
  import i2f_pack_pkg::*;
#(
  parameter int INT_W = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W = 1 + EXP_W + MAN_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int CW   = $clog2(INT_W + 1)
) (
  input  logic [INT_W-1:0] val_i,
  input  rmode_e           rmode_i,
  output logic [FP_W-1:0]  fp_o,
  output logic             inexact_o
);
  logic             sgn;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] norm;
  logic [CW-1:0]    lz;
  logic             is_zero;
  logic             guard, sticky, lsb, inc;
  logic [MAN_W+1:0] sig_rnd;
  logic [EXP_W-1:0] exp_raw, exp_fin;

  assign sgn = val_i[INT_W-1];
  assign mag = sgn ? (~val_i + 1'b1) : val_i;

  i2f_pack_lzc #(.W(INT_W)) u_lzc (
    .val_i (mag),
    .cnt_o (lz),
    .zero_o(is_zero)
  );

  always_comb begin
    norm   = mag << lz;
    lsb    = norm[INT_W-2-MAN_W+1];
    guard  = norm[INT_W-2-MAN_W];
    sticky = |norm[INT_W-3-MAN_W:0];
    unique case (rmode_i)
      RM_NEAR: inc = guard & (sticky | lsb);
      RM_DOWN: inc = sgn & (guard | sticky);
      RM_UP:   inc = ~sgn & (guard | sticky);
      default: inc = 1'b0;
    endcase
    sig_rnd = {1'b0, 1'b1, norm[INT_W-2 -: MAN_W]} + (MAN_W+2)'(inc);
    exp_raw = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);
    exp_fin = exp_raw + EXP_W'(sig_rnd[MAN_W+1]);
    if (is_zero) begin
      fp_o      = '0;
      inexact_o = 1'b0;
    end else begin
      fp_o      = {sgn, exp_fin, sig_rnd[MAN_W-1:0]};
      inexact_o = guard | sticky;
    end
  end
endmodule

// File: rtl/i2f_pack_ctl.sv
module i2f_pack_ctl
  import i2f_pack_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]       vl_sel_i,
  input  logic [3:0]       resv_i,
  input  logic [2:0]       rnd_i,
  input  logic             bcast_i,
  output logic [LANES-1:0] lane_act_o,
  output logic             illegal_o,
  output rmode_e           rmode_o
);
  int unsigned n_act;

  always_comb begin
    unique case (vlen_e'(vl_sel_i))
      LEN_2:   n_act = 2;
      LEN_4:   n_act = 4;
      LEN_8:   n_act = 8;
      default: n_act = 0;
    endcase
    for (int j = 0; j < LANES; j++) lane_act_o[j] = (j < n_act);
    illegal_o = (resv_i != RESV_OK) ||
                (vlen_e'(vl_sel_i) == LEN_BAD) ||
                (rnd_i[2] && ((vlen_e'(vl_sel_i) != LEN_8) || bcast_i));
    rmode_o   = rnd_i[2] ? rmode_e'(rnd_i[1:0]) : RM_NEAR;
  end
endmodule

// File: rtl/i2f_pack.sv
module i2f_pack
  import i2f_pack_pkg::*;
#(
  parameter int LANES = 8,
  parameter int INT_W = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W  = 1 + EXP_W + MAN_W,
  localparam int VEC_W = LANES * INT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] old_dst_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             mask_en_i,
  input  logic [1:0]       vl_sel_i,
  input  logic             zero_mode_i,
  input  logic             bcast_i,
  input  logic [2:0]       rnd_i,
  input  logic [3:0]       resv_i,
  output logic [VEC_W-1:0] dst_o,
  output logic             inexact_o,
  output logic             illegal_o
);
  logic [LANES-1:0] lane_act, take, lane_inx;
  logic [FP_W-1:0]  lane_fp [LANES];
  logic             illegal_n, inexact_n;
  logic [VEC_W-1:0] dst_n, keep_n;
  rmode_e           rmode;

  i2f_pack_ctl #(.LANES(LANES)) u_ctl (
    .vl_sel_i  (vl_sel_i),
    .resv_i    (resv_i),
    .rnd_i     (rnd_i),
    .bcast_i   (bcast_i),
    .lane_act_o(lane_act),
    .illegal_o (illegal_n),
    .rmode_o   (rmode)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [INT_W-1:0] elem;
    assign elem    = bcast_i ? src_i[INT_W-1:0] : src_i[j*INT_W +: INT_W];
    assign take[j] = lane_act[j] & (~mask_en_i | mask_i[j]) & ~illegal_n;

    i2f_pack_conv #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_conv (
      .val_i    (elem),
      .rmode_i  (rmode),
      .fp_o     (lane_fp[j]),
      .inexact_o(lane_inx[j])
    );

    // R4: a masked-off lane reads zero in zeroing mode, old value when merging
    p_zero_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_act[j] && !take[j] && !illegal_n && zero_mode_i)
      |=> (dst_o[j*FP_W +: FP_W] == '0));
    p_merge_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_act[j] && !take[j] && !illegal_n && !zero_mode_i)
      |=> (dst_o[j*FP_W +: FP_W] == $past(old_dst_i[j*FP_W +: FP_W])));
  end

  // next-state
  always_comb begin
    dst_n     = '0;
    keep_n    = '0;
    inexact_n = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (lane_act[j]) keep_n[j*FP_W +: FP_W] = '1;
      if (take[j]) begin
        dst_n[j*FP_W +: FP_W] = lane_fp[j];
        inexact_n = inexact_n | lane_inx[j];
      end else if (lane_act[j] && !illegal_n && !zero_mode_i) begin
        dst_n[j*FP_W +: FP_W] = old_dst_i[j*FP_W +: FP_W];
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o     <= '0;
      inexact_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      dst_o     <= dst_n;
      inexact_o <= inexact_n;
      illegal_o <= illegal_n;
    end
  end

  // R7: bad reserved field flags illegal and silences the outputs
  p_resv_illegal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resv_i != RESV_OK) |=> illegal_o);
  p_illegal_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_n |=> (dst_o == '0 && !inexact_o));
  // R6: bits above the active half-width stay zero
  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_act != '0) |=> ((dst_o & ~$past(keep_n)) == '0));
  // R8: no converted lane means no inexact report
  p_masked_inexact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take == '0) |=> !inexact_o);
endmodule

// File: tb/i2f_pack_tb.sv
`timescale 1ns/100ps
module i2f_pack_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [511:0] src, old_dst, dst;
  logic [7:0]   mask;
  logic         mask_en, zero_mode, bcast, inexact, illegal;
  logic [1:0]   vl_sel;
  logic [2:0]   rnd;
  logic [3:0]   resv;
  int           n_run = 0, n_fail = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  i2f_pack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .old_dst_i(old_dst),
    .mask_i(mask), .mask_en_i(mask_en), .vl_sel_i(vl_sel),
    .zero_mode_i(zero_mode), .bcast_i(bcast), .rnd_i(rnd), .resv_i(resv),
    .dst_o(dst), .inexact_o(inexact), .illegal_o(illegal)
  );

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    src = '0; old_dst = '0; mask = '0; mask_en = 0; zero_mode = 0;
    bcast = 0; vl_sel = 2'd2; rnd = 3'b000; resv = 4'hF;
  endtask

  task automatic set_src(input logic [63:0] v [8]);
    for (int j = 0; j < 8; j++) src[64*j +: 64] = v[j];
  endtask

  // apply at negedge, registered result visible by the next negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_lanes(string tag, int n, input logic [31:0] e [8]);
    for (int j = 0; j < n; j++) chk(tag, dst[32*j +: 32], e[j]);
    chk({tag, " upper"}, dst >> (32 * n), '0);
  endtask

  task automatic t_reset();
    rst_n = 0; defaults(); src = '1; old_dst = '1; resv = 4'h0;
    #12;
    chk("R9 dst", dst, '0);
    chk("R9 inexact", inexact, 0);
    chk("R9 illegal", illegal, 0);
    @(negedge clk); rst_n = 1; defaults(); step();
  endtask

  task automatic t_len2();
    logic [63:0] v [8] = '{64'd1, -64'sd1, 64'd5, 64'd6, 64'd7, 64'd8, 64'd9, 64'd10};
    logic [31:0] e [8] = '{32'h3F800000, 32'hBF800000, 0, 0, 0, 0, 0, 0};
    defaults(); set_src(v); old_dst = '1; vl_sel = 2'd0; step();
    chk_lanes("R1 R2 R6 len2", 2, e);
    chk("R8 exact", inexact, 0);
  endtask

  task automatic t_len8();
    logic [63:0] v [8] = '{64'd0, 64'd2, 64'd3, -64'sd2, 64'd100, -64'sd100,
                           64'd16777217, 64'h8000000000000000};
    logic [31:0] e [8] = '{32'h0, 32'h40000000, 32'h40400000, 32'hC0000000,
                           32'h42C80000, 32'hC2C80000, 32'h4B800000, 32'hDF000000};
    defaults(); set_src(v); old_dst = '1; step();
    chk_lanes("R1 R2 R10 len8", 8, e);
    chk("R8 set", inexact, 1);
    chk("R7 legal", illegal, 0);
  endtask

  task automatic t_len4();
    logic [63:0] v [8] = '{64'd0, 64'd2, 64'd3, -64'sd2, 64'd16777217, 64'd9, 64'd9, 64'd9};
    logic [31:0] e [8] = '{32'h0, 32'h40000000, 32'h40400000, 32'hC0000000, 0, 0, 0, 0};
    defaults(); set_src(v); old_dst = '1; vl_sel = 2'd1; step();
    chk_lanes("R1 R6 len4", 4, e);
    chk("R8 beyond length", inexact, 0);
  endtask

  task automatic t_mask(input bit zm);
    logic [63:0] v [8] = '{64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8};
    logic [31:0] f [8] = '{32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000,
                           32'h40A00000, 32'h40C00000, 32'h40E00000, 32'h41000000};
    logic [31:0] e [8];
    defaults(); set_src(v); mask_en = 1; mask = 8'b1010_0101; zero_mode = zm;
    for (int j = 0; j < 16; j++) old_dst[32*j +: 32] = 32'hA0000000 + j;
    for (int j = 0; j < 8; j++)
      e[j] = mask[j] ? f[j] : (zm ? 32'h0 : 32'hA0000000 + j);
    step();
    chk_lanes(zm ? "R4 zeroing" : "R4 merging", 8, e);
  endtask

  task automatic t_nomask();
    logic [63:0] v [8] = '{64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8};
    defaults(); set_src(v); mask = 8'h00; mask_en = 0; zero_mode = 1; step();
    chk("R4 mask disabled", dst[255:224], 32'h41000000);
  endtask

  task automatic t_masked_inexact();
    logic [63:0] v [8] = '{64'd16777217, 64'd1, 64'd16777217, 0, 0, 0, 0, 0};
    defaults(); set_src(v); vl_sel = 2'd0; mask_en = 1; mask = 8'b0000_0110; step();
    chk("R8 masked lane", inexact, 0);
    chk("R8 lane1", dst[63:32], 32'h3F800000);
  endtask

  task automatic t_bcast();
    logic [63:0] v [8] = '{64'd7, 64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd8};
    logic [31:0] e [8] = '{32'h40E00000, 32'h40E00000, 32'h40E00000, 32'h40E00000,
                           0, 0, 0, 0};
    defaults(); set_src(v); vl_sel = 2'd1; bcast = 1; step();
    chk_lanes("R5 broadcast", 4, e);
  endtask

  task automatic t_round(input logic [1:0] m, input logic [31:0] e [8]);
    logic [63:0] v [8] = '{64'd16777217, -64'sd16777217, 64'd16777219, 64'h1FFFFFF,
                           64'h7FFFFFFFFFFFFFFF, -64'sd1, 64'd0, 64'd1};
    defaults(); set_src(v); rnd = {1'b1, m}; step();
    chk_lanes($sformatf("R3 R10 mode %0d", m), 8, e);
    chk("R3 inexact", inexact, 1);
    chk("R3 R7 override legal", illegal, 0);
  endtask

  task automatic t_default_round();
    logic [63:0] v [8] = '{64'h1FFFFFF, 64'd16777219, 0, 0, 0, 0, 0, 0};
    defaults(); set_src(v); rnd = 3'b011; vl_sel = 2'd2; rnd[2] = 0; step();
    chk("R3 R10 default carry", dst[31:0], 32'h4C000000);
    chk("R3 default tie even", dst[63:32], 32'h4B800002);
  endtask

  task automatic t_illegal();
    logic [63:0] v [8] = '{64'd16777217, 64'd1, 64'd1, 64'd1, 64'd1, 64'd1, 64'd1, 64'd1};
    defaults(); set_src(v); old_dst = '1; resv = 4'h7; step();
    chk("R7 resv dst", dst, '0); chk("R7 resv flag", illegal, 1);
    chk("R7 resv inexact", inexact, 0);
    defaults(); set_src(v); vl_sel = 2'd3; step();
    chk("R7 length 3", illegal, 1);
    defaults(); set_src(v); vl_sel = 2'd1; rnd = 3'b100; step();
    chk("R7 override len4", illegal, 1);
    defaults(); set_src(v); bcast = 1; rnd = 3'b111; step();
    chk("R7 override bcast", illegal, 1);
    chk("R7 override bcast dst", dst, '0);
  endtask

  initial begin
    t_reset();
    t_len2();
    t_len8();
    t_len4();
    t_mask(0);
    t_mask(1);
    t_nomask();
    t_masked_inexact();
    t_bcast();
    t_round(2'b00, '{32'h4B800000, 32'hCB800000, 32'h4B800002, 32'h4C000000,
                     32'h5F000000, 32'hBF800000, 32'h0, 32'h3F800000});
    t_round(2'b01, '{32'h4B800000, 32'hCB800001, 32'h4B800001, 32'h4BFFFFFF,
                     32'h5EFFFFFF, 32'hBF800000, 32'h0, 32'h3F800000});
    t_round(2'b10, '{32'h4B800001, 32'hCB800000, 32'h4B800002, 32'h4C000000,
                     32'h5F000000, 32'hBF800000, 32'h0, 32'h3F800000});
    t_round(2'b11, '{32'h4B800000, 32'hCB800000, 32'h4B800001, 32'h4BFFFFFF,
                     32'h5EFFFFFF, 32'hBF800000, 32'h0, 32'h3F800000});
    t_default_round();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule